// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers eight interrupt request pins and drives one interrupt line toward a processor. Each pin is either edge sensed, on a rising edge, or level sensed; the choice is made per pin through a mode register. Every pin passes through a two-stage synchroniser before it is used. A request register shows the pending requests. A mask register can keep any request from raising the interrupt line. An in-service register records which requests the processor is currently handling.

Priority is fixed: pin 0 is the most urgent and pin 7 the least. The interrupt line is raised when an unmasked pending request outranks every request already in service. This allows a more urgent request to interrupt the handling of a less urgent one. When the processor pulses the acknowledge input, the block presents an 8-bit vector made of a programmable 5-bit base and the 3-bit index of the winning pin. On that same edge it marks the winner as in service. A write of the value 0x20 to the command address retires the most urgent in-service entry. This is a non-specific end-of-interrupt.

All registers sit behind a simple port. Writes are synchronous and reads are combinational.

Top module: `nest_intc`

## Requirements
- R1: On an acknowledge while the interrupt line is high, the block sets exactly one in-service bit, the one for the lowest-indexed unmasked pending request. During that acknowledge cycle `ack_vector` equals {base[4:0], index[2:0]}.
- R2: For an edge-mode pin, the acknowledge clears that pin's request bit. The bit stays clear while the pin is held high, and it is set again by the next rising edge of the pin.
- R3: For a level-mode pin (mode bit = 1), the request bit follows the synchronised pin level. An acknowledge does not clear it.
- R4: `int_out` is high exactly when some unmasked pending request has a lower index than every set in-service bit. When no in-service bit is set, any unmasked pending request is enough.
- R5: A request that outranks the in-service entry raises `int_out` during service. Acknowledging it adds a second in-service bit, and the first bit is kept (nesting).
- R6: A write of 0x20 to address 4 clears only the lowest-indexed set in-service bit. Any other value written there changes nothing.
- R7: If a request is still pending and unmasked when an end-of-interrupt clears the in-service bit above it, `int_out` is high in the cycle right after the write.
- R8: A mask bit of 1 keeps the matching request from raising `int_out`. The request bit itself still shows in the request register.
- R9: The register addresses are 0 request (read only), 1 in-service (read only), 2 mask, 3 mode (1 = level), 4 command (write only, reads 0) and 5 base (the value is held in bits 7:3). Reset clears every register.
- R10: An acknowledge while `int_out` is low returns {base, 3'd7} and leaves the in-service register unchanged.
- R11: Writing address 5 changes bits 7:3 of every later vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 8 | Asynchronous request pins, bit 0 most urgent |
| ack_in | input | 1 | One-cycle acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt line to the processor |
| ack_vector | output | 8 | Vector presented during the acknowledge cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The hardest state to reach is two nested in-service bits with a lower-priority edge request pending below both. Retiring them one at a time must first keep `int_out` low and then raise it at once. The stimulus gets there in order. It raises pin 3 and acknowledges it, then raises pin 5, which must stay silent. It then raises pin 1, acknowledges it for nesting, and issues two end-of-interrupt writes, with reads of the in-service register between them. A level pin held high through its own end-of-interrupt, and a pin held high through its own acknowledge, cover the re-assert and re-arm corners.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;

    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int VEC_W   = 8;
    localparam int BASE_W  = VEC_W - IDX_W;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int SYNC_STAGES = 2;

    localparam logic [DATA_W-1:0] CMD_NS_EOI = 8'h20;
    localparam logic [IDX_W-1:0]  IDLE_IDX   = IDX_W'(NUM_IRQ - 1);

    typedef enum logic [ADDR_W-1:0] {
        RA_PEND  = 3'd0,
        RA_INSVC = 3'd1,
        RA_MASK  = 3'd2,
        RA_MODE  = 3'd3,
        RA_CMD   = 3'd4,
        RA_BASE  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // lowest set index wins (index 0 is most urgent)
    function automatic pick_t pick_first(input logic [NUM_IRQ-1:0] v);
        pick_t p;
        p.found = 1'b0;
        p.idx   = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [NUM_IRQ-1:0] idx_onehot(input logic [IDX_W-1:0] idx);
        logic [NUM_IRQ-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/nest_intc_capture.sv
module nest_intc_capture
    import nest_intc_pkg::*;
#(
    parameter int N = NUM_IRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] level_mode,
    input  logic [N-1:0] ack_clear,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;
        logic                   latch_q;
        logic                   synced;
        logic                   rise;

        assign synced = sync_q[SYNC_STAGES-1];
        assign rise   = synced & ~prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q  <= '0;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                sync_q  <= {sync_q[SYNC_STAGES-2:0], pin[g]};
                prev_q  <= synced;
                if (level_mode[g])
                    latch_q <= 1'b0;
                else if (rise)
                    latch_q <= 1'b1;
                else if (ack_clear[g])
                    latch_q <= 1'b0;
            end
        end

        assign pend[g] = level_mode[g] ? synced : latch_q;
    end

endmodule

// File: rtl/nest_intc_resolve.sv
module nest_intc_resolve
    import nest_intc_pkg::*;
(
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] insvc,
    output pick_t              req_pick,
    output pick_t              svc_pick,
    output logic               fire
);

    assign req_pick = pick_first(pend & ~mask);
    assign svc_pick = pick_first(insvc);
    assign fire     = req_pick.found &&
                      (!svc_pick.found || (req_pick.idx < svc_pick.idx));

endmodule

// File: rtl/nest_intc.sv
module nest_intc
    import nest_intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic               ack_in,
    output logic               int_out,
    output logic [VEC_W-1:0]   ack_vector,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);

    logic [NUM_IRQ-1:0] mask_q, mode_q, insvc_q;
    logic [BASE_W-1:0]  base_q;
    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] grant, retire;
    logic               eoi_hit;
    pick_t              req_pick, svc_pick;
    logic               fire;
    reg_addr_e          addr;

    assign addr = reg_addr_e'(reg_addr);

    nest_intc_capture #(.N(NUM_IRQ)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .pin        (irq_pin),
        .level_mode (mode_q),
        .ack_clear  (grant),
        .pend       (pend)
    );

    nest_intc_resolve u_resolve (
        .pend     (pend),
        .mask     (mask_q),
        .insvc    (insvc_q),
        .req_pick (req_pick),
        .svc_pick (svc_pick),
        .fire     (fire)
    );

    assign eoi_hit = reg_wr && (addr == RA_CMD) && (reg_wdata == CMD_NS_EOI);
    assign grant   = (ack_in && fire) ? idx_onehot(req_pick.idx) : '0;
    assign retire  = (eoi_hit && svc_pick.found) ? idx_onehot(svc_pick.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            mode_q  <= '0;
            insvc_q <= '0;
            base_q  <= '0;
        end else begin
            insvc_q <= (insvc_q & ~retire) | grant;
            if (reg_wr) begin
                unique case (addr)
                    RA_MASK: mask_q <= reg_wdata[NUM_IRQ-1:0];
                    RA_MODE: mode_q <= reg_wdata[NUM_IRQ-1:0];
                    RA_BASE: base_q <= reg_wdata[DATA_W-1:IDX_W];
                    default: ;
                endcase
            end
        end
    end

    assign int_out    = fire;
    assign ack_vector = {base_q, fire ? req_pick.idx : IDLE_IDX};

    always_comb begin
        unique case (addr)
            RA_PEND:  reg_rdata = DATA_W'(pend);
            RA_INSVC: reg_rdata = DATA_W'(insvc_q);
            RA_MASK:  reg_rdata = DATA_W'(mask_q);
            RA_MODE:  reg_rdata = DATA_W'(mode_q);
            RA_BASE:  reg_rdata = {base_q, {IDX_W{1'b0}}};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk
    import nest_intc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ack_in,
    input logic               int_out,
    input logic               eoi_hit,
    input logic [NUM_IRQ-1:0] insvc_q,
    input logic [NUM_IRQ-1:0] pend,
    input logic [NUM_IRQ-1:0] mask_q
);

    AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        (ack_in && int_out && !eoi_hit) |=>
            ($countones(insvc_q) == $countones($past(insvc_q)) + 1)); // R1

    AST_NEW_SVC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        !ack_in |=> (insvc_q & ~$past(insvc_q)) == '0); // R5

    AST_IDLE_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !int_out && !eoi_hit) |=> $stable(insvc_q)); // R10

    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (eoi_hit && !ack_in && (insvc_q != '0)) |=>
            ($countones(insvc_q) + 1 == $countones($past(insvc_q)))); // R6

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((pend & ~mask_q) != '0)); // R8

endmodule

bind nest_intc nest_intc_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ack_in  (ack_in),
    .int_out (int_out),
    .eoi_hit (eoi_hit),
    .insvc_q (insvc_q),
    .pend    (pend),
    .mask_q  (mask_q)
);

// File: tb/tb_nest_intc.sv
module tb_nest_intc;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_pin = '0;
    logic       ack_in = 1'b0;
    logic       int_out;
    logic [7:0] ack_vector;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nest_intc dut (
        .clk(clk), .rst(rst), .irq_pin(irq_pin), .ack_in(ack_in),
        .int_out(int_out), .ack_vector(ack_vector), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_int(input logic exp, input string tag);
        #1;
        check(tag, {7'd0, int_out}, {7'd0, exp});
    endtask

    // driver: pushes the expected vector, then pulses acknowledge
    task automatic do_ack(input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
    endtask

    // monitor: compares the vector presented during each acknowledge cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (ack_in) begin
                if (exp_q.size() == 0) begin
                    check("ack_unexpected", ack_vector, 8'hxx);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, ack_vector, e);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        check_reg(3'd0, 8'h00, "R9 reset pend");
        check_reg(3'd1, 8'h00, "R9 reset insvc");
        check_reg(3'd2, 8'h00, "R9 reset mask");
        check_reg(3'd3, 8'h00, "R9 reset mode");
        check_int(1'b0, "R4 reset int_out");

        write_reg(3'd5, 8'h40);
        check_reg(3'd5, 8'h40, "R11 base readback");

        // edge request on pin 3
        irq_pin[3] = 1'b1; wait_cyc(4);
        check_int(1'b1, "R4 single request");
        check_reg(3'd0, 8'h08, "R2 edge pending");
        do_ack(8'h43, "R1 vector pin3");
        check_reg(3'd1, 8'h08, "R1 insvc pin3");
        check_reg(3'd0, 8'h00, "R2 cleared while held high");
        check_int(1'b0, "R4 drop after ack");

        // lower priority arrives: silent
        irq_pin[5] = 1'b1; wait_cyc(4);
        check_int(1'b0, "R4 lower priority silent");
        check_reg(3'd0, 8'h20, "R4 pin5 pending");

        // higher priority arrives: nests
        irq_pin[1] = 1'b1; wait_cyc(4);
        check_int(1'b1, "R5 higher reasserts");
        do_ack(8'h41, "R5 nested vector");
        check_reg(3'd1, 8'h0A, "R5 two insvc bits");
        check_int(1'b0, "R5 quiet after nest");

        write_reg(3'd4, 8'h60);
        check_reg(3'd1, 8'h0A, "R6 other command ignored");
        write_reg(3'd4, 8'h20);
        check_reg(3'd1, 8'h08, "R6 eoi clears highest");
        check_int(1'b0, "R6 pin5 still below pin3");
        write_reg(3'd4, 8'h20);
        check_reg(3'd1, 8'h00, "R6 second eoi");
        check_int(1'b1, "R7 pending pin5 after eoi");
        do_ack(8'h45, "R1 vector pin5");
        check_reg(3'd1, 8'h20, "R1 insvc pin5");
        write_reg(3'd4, 8'h20);

        // re-arm of edge pin 3
        irq_pin[3] = 1'b0; wait_cyc(4);
        check_reg(3'd0, 8'h00, "R2 no request on fall");
        irq_pin[3] = 1'b1; wait_cyc(4);
        check_reg(3'd0, 8'h08, "R2 new edge sets again");
        do_ack(8'h43, "R2 vector after rearm");
        write_reg(3'd4, 8'h20);

        // level pin 2
        write_reg(3'd3, 8'h04);
        check_reg(3'd3, 8'h04, "R9 mode readback");
        irq_pin[2] = 1'b1; wait_cyc(4);
        check_reg(3'd0, 8'h04, "R3 level pending");
        do_ack(8'h42, "R3 level vector");
        check_reg(3'd0, 8'h04, "R3 not cleared by ack");
        check_reg(3'd1, 8'h04, "R3 insvc pin2");
        check_int(1'b0, "R4 own level in service");
        write_reg(3'd4, 8'h20);
        check_int(1'b1, "R7 level reasserts at eoi");
        irq_pin[2] = 1'b0; wait_cyc(3);
        check_reg(3'd0, 8'h00, "R3 follows pin low");
        check_int(1'b0, "R3 line low after pin low");

        // masking
        irq_pin[2] = 1'b1; wait_cyc(4);
        check_int(1'b1, "R8 before mask");
        write_reg(3'd2, 8'h04);
        check_int(1'b0, "R8 masked quiet");
        check_reg(3'd0, 8'h04, "R8 pending still visible");
        check_reg(3'd2, 8'h04, "R9 mask readback");
        do_ack(8'h47, "R10 idle ack vector");
        check_reg(3'd1, 8'h00, "R10 insvc unchanged");

        // base change
        write_reg(3'd5, 8'hA8);
        write_reg(3'd2, 8'h00);
        do_ack(8'hAA, "R11 new base vector");
        check_reg(3'd1, 8'h04, "R11 insvc after ack");

        // reset clears all
        @(negedge clk); rst = 1'b1;
        wait_cyc(2); rst = 1'b0;
        check_reg(3'd1, 8'h00, "R9 reset insvc again");
        check_reg(3'd2, 8'h00, "R9 reset mask again");
        check_reg(3'd3, 8'h00, "R9 reset mode again");
        check_reg(3'd5, 8'h00, "R9 reset base");

        wait_cyc(2);
        if (exp_q.size() != 0) check("R1 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule